// File: doc/BRIEF.md
# Address-Strobed Burst Read Port

This block is the read side of a flash-style memory with two ways to read. In random mode, which is selected by holding the burst-select input high, the address passes through a transparent latch. The latch is open while chip enable and the address strobe are both low, and it closes when the strobe rises. Array data follows the latched address with no clock involved.

In burst mode, which is selected by holding burst-select low, the start address is captured on a rising clock edge at which the strobe is low. After a fixed number of clock edges set by a parameter, the block presents one word per clock at consecutive addresses. The ready output marks the latency window.

Chip enable and output enable control the enable of the tri-state data bus. Raising chip enable ends a burst. The array is behavioural: every word is a fixed function of its address, so the data on the bus shows which address was read.

Top module: `burst_read_if`

## Requirements
- R1: `dq_oe` is high exactly when `ce_n` and `oe_n` are both low. Whenever `dq_oe` is low, `dq_o` is all zeros.
- R2: With `burst_n` high, `ce_n` low and `adv_n` low, the address is transparent: `dq_o` follows `word(addr)` without any clock edge.
- R3: In random mode the address is held from the rising edge of `adv_n`. Later changes on `addr` do not alter `dq_o`. A low pulse on `adv_n` while `ce_n` is high leaves the held address unchanged.
- R4: The word stored at address A is `(A ^ (A >> 4))` truncated to its low 16 bits.
- R5: At a rising clock edge where `ce_n`, `adv_n` and `burst_n` are all low, the address is captured as a burst start. `rdy` goes low after that edge, and this restarts a burst that is already running.
- R6: `rdy` stays low for exactly LATENCY clock edges, counting the capture edge. After the LATENCY-th edge following the capture, `rdy` is high and `dq_o` shows the word at the start address.
- R7: Each further rising edge in a burst advances the presented address by one.
- R8: A burst that passes address 0xFFFFF continues at address 0.
- R9: A rising edge with `ce_n` high returns the burst logic to idle, and `rdy` is then high.
- R10: `oe_n` does not stall a burst. The address keeps advancing while the outputs are disabled.
- R11: After reset, `rdy` is high, the burst logic is idle and the held random-mode address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| burst_n | input | 1 | Low selects burst mode, high selects random mode |
| addr | input | 20 | Word address |
| dq_o | output | 16 | Read data |
| dq_oe | output | 1 | Enable for the external tri-state data driver |
| rdy | output | 1 | Low while burst data is not yet valid |

## Verification
Random reads are tried three ways: with the strobe open so that data follows the address, with the strobe closed so that address changes must be ignored, and with a strobe pulse while the chip is disabled, which separates a latch gated by chip enable from one that is not. Bursts are run from an ordinary start address and from just below the top of the space. A scoreboard compares each word with the expected sequence and counts the edges with ready low, which separates a correct latency from one that is off by one and a correct wrap from a carry out of range. Two further bursts cover the remaining cases: in one the strobe is pulsed again mid-burst to show the restart, and in the other output enable is held high early on to show that disabling the outputs does not freeze the address counter.

// File: rtl/burst_read_pkg.sv
`timescale 1ns/1ps
package burst_read_pkg;
  typedef enum logic [1:0] {
    BR_IDLE   = 2'd0,
    BR_WAIT   = 2'd1,
    BR_STREAM = 2'd2
  } brst_state_t;
endpackage

// File: rtl/avd_addr_latch.sv
`timescale 1ns/1ps
// Transparent address holder for random reads: open while en is high.
module avd_addr_latch #(
  parameter int ADDR_W = 20
) (
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q
);
  always_latch begin
    if (!rst_n)  addr_q <= '0;
    else if (en) addr_q <= addr_i;
  end
endmodule

// File: rtl/word_array.sv
`timescale 1ns/1ps
// Behavioural array: every word is a fixed function of its address.
module word_array #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int MIX_SHIFT = 4;
  logic [ADDR_W-1:0] mixed;
  always_comb begin
    mixed  = addr_i ^ (addr_i >> MIX_SHIFT);
    data_o = DATA_W'(mixed);
  end
endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
// Burst sequencer: start capture, latency countdown, address advance.
module burst_seq
  import burst_read_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              burst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] burst_addr_o,
  output logic              streaming_o,
  output logic              waiting_o
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam int WW = CW + 1;

  brst_state_t       st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] ba_q, ba_d;
  logic              ba_en, start;

  assign start = !ce_n && !adv_n && !burst_n;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ba_d  = ba_q;
    ba_en = 1'b0;
    if (start) begin
      st_d  = BR_WAIT;
      cnt_d = CW'(LATENCY - 1);
      ba_d  = addr_i;
      ba_en = 1'b1;
    end else if (ce_n) begin
      st_d = BR_IDLE;
    end else begin
      case (st_q)
        BR_WAIT: begin
          if (cnt_q == '0) st_d = BR_STREAM;
          else             cnt_d = cnt_q - 1'b1;
        end
        BR_STREAM: begin
          ba_d  = ba_q + 1'b1;
          ba_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BR_IDLE;
      cnt_q <= '0;
      ba_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (ba_en) ba_q <= ba_d;
    end
  end

  assign burst_addr_o = ba_q;
  assign streaming_o  = (st_q == BR_STREAM);
  assign waiting_o    = (st_q == BR_WAIT);

  // Checker state: edges spent in the latency window since the capture.
  logic [WW-1:0] wait_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               wait_len <= '0;
    else if (start)           wait_len <= '0;
    else if (st_q == BR_WAIT) wait_len <= wait_len + 1'b1;
  end

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_q == BR_WAIT && ba_q == $past(addr_i)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BR_STREAM && $past(st_q) == BR_WAIT) |-> (wait_len == WW'(LATENCY)));

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BR_STREAM && !ce_n && !start) |=> (ba_q == ADDR_W'($past(ba_q) + 1'b1)));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BR_STREAM && ba_q == '1 && !ce_n && !start) |=> (ba_q == '0));

  assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (st_q == BR_IDLE));
endmodule

// File: rtl/burst_read_if.sv
`timescale 1ns/1ps
module burst_read_if #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic              burst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rdy
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic              lat_en, streaming, waiting;
  logic [ADDR_W-1:0] rand_addr, burst_addr, rd_addr;
  logic [DATA_W-1:0] word;

  assign lat_en = !ce_n && !adv_n && burst_n;

  avd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .rst_n  (rst_sync_n),
    .en     (lat_en),
    .addr_i (addr),
    .addr_q (rand_addr)
  );

  burst_seq #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ce_n         (ce_n),
    .adv_n        (adv_n),
    .burst_n      (burst_n),
    .addr_i       (addr),
    .burst_addr_o (burst_addr),
    .streaming_o  (streaming),
    .waiting_o    (waiting)
  );

  assign rd_addr = streaming ? burst_addr : rand_addr;

  word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .addr_i (rd_addr),
    .data_o (word)
  );

  assign dq_oe = !ce_n && !oe_n;
  assign dq_o  = dq_oe ? word : '0;
  assign rdy   = !waiting;

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dq_oe |-> (dq_o == '0));

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_n |=> rdy);
endmodule

// File: tb/burst_read_if_test.sv
`timescale 1ns/1ps
module burst_read_if_test;
  localparam int AW  = 20;
  localparam int DW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ce_n, oe_n, adv_n, burst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_o;
  logic dq_oe, rdy;

  burst_read_if #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
    .burst_n(burst_n), .addr(addr), .dq_o(dq_o), .dq_oe(dq_oe), .rdy(rdy)
  );

  int total = 0;
  int bad   = 0;

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    logic [AW-1:0] m;
    m = a ^ (a >> 4);
    return m[DW-1:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard: expected burst words queued by the driver, popped by the monitor.
  logic [DW-1:0] exp_q[$];
  bit    mon_on = 1'b0;
  bit    got_first;
  int    wait_seen;
  string cur_tag;

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (!rdy) wait_seen++;
      else if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        if (!got_first) begin
          check(wait_seen == LAT, "R6 latency edges", wait_seen, LAT);
          got_first = 1'b1;
        end
        e = exp_q.pop_front();
        check(dq_oe && dq_o == e, cur_tag, dq_o, e);
      end
    end
  end

  task automatic run_burst(logic [AW-1:0] start, int n, string tag);
    @(negedge clk);
    ce_n = 0; oe_n = 0; burst_n = 0; adv_n = 0; addr = start;
    for (int i = 0; i < n; i++) exp_q.push_back(word_of(AW'(start + i)));
    cur_tag = tag; wait_seen = 0; got_first = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    adv_n = 1; addr = 20'h0BEEF;
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0; ce_n = 1;
    @(posedge clk); #2;
    check(rdy == 1'b1, "R9 rdy after end", rdy, 1);
    check(dq_oe == 1'b0 && dq_o == '0, "R1 bus off after end", dq_o, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; ce_n = 1; oe_n = 1; adv_n = 1; burst_n = 1; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // Reset state
    check(rdy == 1'b1, "R11 rdy after reset", rdy, 1);
    check(dq_oe == 1'b0 && dq_o == '0, "R1 bus off in reset state", dq_o, 0);
    ce_n = 0; oe_n = 0; #1;
    check(dq_o == word_of('0), "R11 held address zero", dq_o, word_of('0));

    // Random mode: flow-through
    @(negedge clk);
    adv_n = 0; addr = 20'h12345; #1;
    check(dq_oe && dq_o == word_of(20'h12345), "R2 flow-through R4", dq_o, word_of(20'h12345));
    addr = 20'hA5A5A; #1;
    check(dq_o == word_of(20'hA5A5A), "R2 follows address", dq_o, word_of(20'hA5A5A));
    adv_n = 1; #1;
    addr = 20'h00777; #1;
    check(dq_o == word_of(20'hA5A5A), "R3 held after strobe rise", dq_o, word_of(20'hA5A5A));
    // Output enable gating
    oe_n = 1; #1;
    check(dq_oe == 1'b0 && dq_o == '0, "R1 oe_n high", dq_o, 0);
    oe_n = 0; #1;
    // Strobe pulse with chip disabled is ignored
    ce_n = 1; #1;
    check(dq_oe == 1'b0, "R1 ce_n high", dq_oe, 0);
    adv_n = 0; addr = 20'h55555; #1;
    adv_n = 1; #1;
    ce_n = 0; #1;
    check(dq_o == word_of(20'hA5A5A), "R3 strobe ignored with ce_n high", dq_o, word_of(20'hA5A5A));
    check(rdy == 1'b1, "R11 rdy high in random mode", rdy, 1);
    @(negedge clk); ce_n = 1;

    // Bursts through the scoreboard
    run_burst(20'h01230, 8, "R7 sequential word");
    run_burst(20'hFFFFE, 5, "R8 wrap word");

    // Restart a running burst
    @(negedge clk);
    ce_n = 0; oe_n = 0; burst_n = 0; adv_n = 0; addr = 20'h04000;
    @(negedge clk); adv_n = 1;
    repeat (LAT + 1) @(negedge clk);
    adv_n = 0; addr = 20'h09990;
    @(posedge clk); #2;
    check(rdy == 1'b0, "R5 restart drops rdy", rdy, 0);
    @(negedge clk); adv_n = 1;
    repeat (LAT) @(posedge clk); #2;
    check(rdy && dq_o == word_of(20'h09990), "R5 restart start word", dq_o, word_of(20'h09990));
    @(negedge clk); ce_n = 1;
    @(posedge clk); #2;
    check(rdy == 1'b1, "R9 idle after restart burst", rdy, 1);

    // Address keeps advancing with the outputs disabled
    @(negedge clk);
    ce_n = 0; oe_n = 1; burst_n = 0; adv_n = 0; addr = 20'h30003;
    @(negedge clk); adv_n = 1;
    repeat (LAT + 2) @(posedge clk);
    #1;
    check(dq_oe == 1'b0 && dq_o == '0, "R1 burst with oe_n high", dq_o, 0);
    oe_n = 0; #0.5;
    check(dq_o == word_of(20'h30005), "R10 advance while disabled", dq_o, word_of(20'h30005));
    @(negedge clk); ce_n = 1; burst_n = 1;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule